// File: doc/BRIEF.md
# Dual-Channel Performance Event Counter

This block is a small performance monitoring unit with two event counters, reached over a simple single-cycle register bus. Each channel has a control word and a count word. The control word picks one of a set of hardware event strobes by an event code, and carries three arming bits that must all be set before the channel counts. A shared status word holds a clear strobe and a sticky overflow flag for each channel.

Software first clears a channel. It then writes the event code and the two mode bits. A separate write then sets the count-enable bit. From the next clock on, the count word goes up by one in every cycle in which the chosen strobe is high. The count width is a parameter (32 by default). When the count wraps from its maximum back to zero, the channel's overflow flag is set. A clear resets both the count and the flag.

Top module: `perf_mon_dual`

## Requirements
- R1: Word registers sit at byte addresses 0x00 (control, channel 0), 0x04 (control, channel 1), 0x08 (count, channel 0), 0x0C (count, channel 1) and 0x10 (shared status). A control word keeps only bits 16:6 (event code), bit 3 (count enable), bit 1 and bit 0 (mode bits), reads back as last written with all other bits zero, and is zero after reset. The count and status words are zero after reset. Writes to count words are ignored. An address with nonzero low two bits or no mapped register reads zero.
- R2: A channel counts only while its count-enable bit, bit 1 and bit 0 are all set. With any of the three clear, the count holds.
- R3: An armed channel adds exactly one to its count for each clock cycle in which its selected strobe is high. The new value is readable from the next cycle.
- R4: Event codes map onto `evt_in` as follows. 0x000 counts every cycle. 0x202 counts bit 0 (instructions), 0x204 counts bit 1 (unconditional branches), 0x208 counts bit 2 (exceptions). 0x029 counts bit 3 and 0x02A counts bit 4 (instruction-cache accesses and misses). 0x031 counts bit 5 and 0x032 counts bit 6 (operand-cache read accesses and read misses). 0x039 counts bit 7 and 0x03A counts bit 8 (operand-cache write accesses and write misses).
- R5: Any other event code counts nothing, whatever the strobes do.
- R6: Writing zero to a channel's event code and count-enable bit stops it, and its count keeps its value.
- R7: Writing 1 to bit 1 (channel 0) or bit 9 (channel 1) of the shared word zeroes that channel's count and overflow flag. A clear takes priority over an event in the same cycle and does not touch the other channel. The clear bits read as zero.
- R8: When an increment takes the count from all ones to zero, the channel's overflow flag is set. It reads at shared bit 3 (channel 0) or bit 11 (channel 1) and stays set until cleared.
- R9: Shared bits 0, 8, 16 and 24 are reserved. Writes to them have no effect, and they read as zero.
- R10: A write that sets the count-enable bit does not count in its own cycle. Counting starts in the cycle after it, so N cycles of event code 0x000 after the write give a count of N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe, one cycle |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_in | input | 9 | One-cycle event strobes, bit meaning per R4 |

## Verification
The counting path is driven in four ways: every code with the strobes held high, random strobe noise against each mapped code, an unmapped code with all strobes high, and channels in which one arming bit is missing. Comparing these separates a wrong code-to-strobe mapping from a faulty arming condition. The directed enable sequence pins the exact cycle in which counting starts. A narrow count width lets the wrap run to completion, which shows that the sticky flag is separate from the count value. The random phase interleaves clears, reprogramming and reserved-bit writes on both channels, which exposes cross-channel leakage and errors in clear-versus-event priority.

// File: rtl/pmon_pkg.sv
package pmon_pkg;

  localparam int NUM_CH    = 2;
  localparam int NUM_EVT   = 9;
  localparam int SEL_W     = 11;
  localparam int SEL_LSB   = 6;
  localparam int EN_BIT    = 3;

  // word indices on the register bus
  localparam int WIDX_CTRL0  = 0;
  localparam int WIDX_CNT0   = 2;
  localparam int WIDX_SHARED = 4;

  localparam logic [SEL_W-1:0] CODE_ALL_CYCLES = '0;

  typedef logic [SEL_W-1:0] sel_t;

  typedef struct packed {
    sel_t sel;
    logic cnt_en;
    logic mode_hi;
    logic mode_lo;
  } ctrl_t;

  // event code served by strobe bit i of the event vector
  function automatic sel_t evt_code(input int i);
    case (i)
      0:       return 11'h202;
      1:       return 11'h204;
      2:       return 11'h208;
      3:       return 11'h029;
      4:       return 11'h02A;
      5:       return 11'h031;
      6:       return 11'h032;
      7:       return 11'h039;
      8:       return 11'h03A;
      default: return 11'h7FF;
    endcase
  endfunction

  function automatic ctrl_t ctrl_from_word(input logic [31:0] w);
    ctrl_t c;
    c.sel     = w[SEL_LSB +: SEL_W];
    c.cnt_en  = w[EN_BIT];
    c.mode_hi = w[1];
    c.mode_lo = w[0];
    return c;
  endfunction

  function automatic logic [31:0] ctrl_to_word(input ctrl_t c);
    logic [31:0] w;
    w = '0;
    w[SEL_LSB +: SEL_W] = c.sel;
    w[EN_BIT]           = c.cnt_en;
    w[1]                = c.mode_hi;
    w[0]                = c.mode_lo;
    return w;
  endfunction

  function automatic logic ctrl_is_armed(input ctrl_t c);
    return c.cnt_en & c.mode_hi & c.mode_lo;
  endfunction

  function automatic int clr_bit_pos(input int ch);
    return 1 + 8 * ch;
  endfunction

  function automatic int ovf_bit_pos(input int ch);
    return 3 + 8 * ch;
  endfunction

endpackage

// File: rtl/pmon_evt_sel.sv
module pmon_evt_sel
  import pmon_pkg::*;
(
  input  sel_t               code,
  input  logic [NUM_EVT-1:0] evt,
  output logic               hit,
  output logic               mapped,
  output logic [NUM_EVT-1:0] match
);

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_match
    assign match[i] = (code == evt_code(i));
  end

  logic is_cycles;
  assign is_cycles = (code == CODE_ALL_CYCLES);
  assign mapped    = is_cycles | (|match);
  assign hit       = is_cycles | (|(match & evt));

endmodule

// File: rtl/pmon_channel.sv
module pmon_channel
  import pmon_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrl_we,
  input  ctrl_t              ctrl_wr,
  input  logic               clr,
  input  logic [NUM_EVT-1:0] evt,
  output logic [31:0]        ctrl_word,
  output logic [31:0]        cnt_word,
  output logic               ovf
);

  ctrl_t              ctrl_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               ovf_q;

  logic               sel_hit;
  logic               sel_mapped;
  logic [NUM_EVT-1:0] sel_match;

  pmon_evt_sel u_sel (
    .code   (ctrl_q.sel),
    .evt    (evt),
    .hit    (sel_hit),
    .mapped (sel_mapped),
    .match  (sel_match)
  );

  // named internal events
  logic ch_armed, ch_step, ch_wrap;
  assign ch_armed = ctrl_is_armed(ctrl_q);
  assign ch_step  = ch_armed & sel_hit;
  assign ch_wrap  = ch_step & (cnt_q == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_wr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (clr) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (ch_step) begin
      cnt_q <= cnt_q + 1'b1;
      if (ch_wrap) ovf_q <= 1'b1;
    end
  end

  assign ctrl_word = ctrl_to_word(ctrl_q);
  assign cnt_word  = 32'(cnt_q);
  assign ovf       = ovf_q;

  assert_hold_unarmed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ch_armed && !clr) |=> $stable(cnt_q));

  assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_step && !clr) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  assert_one_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_match));

  assert_unmapped_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_mapped |-> !sel_hit);

  assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0 && !ovf_q));

  assert_wrap_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_wrap && !clr) |=> (ovf_q && cnt_q == '0));

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr) |=> ovf_q);

endmodule

// File: rtl/perf_mon_dual.sv
module perf_mon_dual
  import pmon_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_EVT-1:0] evt_in
);

  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] widx;
  logic              aligned;
  logic              hit_shared;
  ctrl_t             ctrl_wr;

  assign widx       = bus_addr[ADDR_W-1:2];
  assign aligned    = (bus_addr[1:0] == 2'b00);
  assign hit_shared = aligned && (widx == WORD_W'(WIDX_SHARED));
  assign ctrl_wr    = ctrl_from_word(bus_wdata);

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;

  logic [NUM_CH-1:0] ch_ctrl_we;
  logic [NUM_CH-1:0] ch_clr;
  logic [NUM_CH-1:0] ch_ovf;
  logic [31:0]       ch_ctrl_word [NUM_CH];
  logic [31:0]       ch_cnt_word  [NUM_CH];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    assign ch_ctrl_we[ch] = bus_we && aligned && (widx == WORD_W'(WIDX_CTRL0 + ch));
    assign ch_clr[ch]     = bus_we && hit_shared && bus_wdata[clr_bit_pos(ch)];

    pmon_channel #(.CNT_W(CNT_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_we   (ch_ctrl_we[ch]),
      .ctrl_wr   (ctrl_wr),
      .clr       (ch_clr[ch]),
      .evt       (evt_in),
      .ctrl_word (ch_ctrl_word[ch]),
      .cnt_word  (ch_cnt_word[ch]),
      .ovf       (ch_ovf[ch])
    );

    assert_shared_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && hit_shared && bus_wdata[clr_bit_pos(ch)]) |=>
        (ch_cnt_word[ch] == 32'd0 && !ch_ovf[ch]));
  end

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      for (int ch = 0; ch < NUM_CH; ch++) begin
        if (widx == WORD_W'(WIDX_CTRL0 + ch)) bus_rdata = ch_ctrl_word[ch];
        if (widx == WORD_W'(WIDX_CNT0 + ch))  bus_rdata = ch_cnt_word[ch];
      end
      if (hit_shared) begin
        for (int ch = 0; ch < NUM_CH; ch++) bus_rdata[ovf_bit_pos(ch)] = ch_ovf[ch];
      end
    end
  end

  assert_rsvd_no_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && hit_shared && !bus_wdata[1] && !bus_wdata[9]) |-> (ch_clr == '0));

  assert_rsvd_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hit_shared |-> (bus_rdata[0] == 1'b0 && bus_rdata[8] == 1'b0 &&
                    bus_rdata[16] == 1'b0 && bus_rdata[24] == 1'b0));

endmodule

// File: tb/tb_perf_mon_dual.sv
module tb_perf_mon_dual;

  localparam int CNT_W = 10;
  localparam logic [31:0] CMAX = (32'd1 << CNT_W) - 1;
  localparam logic [31:0] CTRL_MASK = 32'h0001_FFCB;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [8:0]  evt_in = '0;

  int errors = 0;
  int checks = 0;

  logic [8:0] evt_rand_en = '0;
  logic [8:0] evt_force   = '0;

  always #2 clk = ~clk;

  perf_mon_dual #(.CNT_W(CNT_W), .ADDR_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in)
  );

  always @(negedge clk) evt_in <= (9'($urandom) & evt_rand_en) | evt_force;

  // strobe selection per R4 / R5
  function automatic logic bhit(input logic [10:0] code, input logic [8:0] e);
    case (code)
      11'h000: return 1'b1;
      11'h202: return e[0];
      11'h204: return e[1];
      11'h208: return e[2];
      11'h029: return e[3];
      11'h02A: return e[4];
      11'h031: return e[5];
      11'h032: return e[6];
      11'h039: return e[7];
      11'h03A: return e[8];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic barmed(input logic [31:0] c);
    return c[3] & c[1] & c[0];
  endfunction

  function automatic logic [10:0] pick_code(input int k);
    case (k)
      0: return 11'h000;  1: return 11'h202;  2: return 11'h204;
      3: return 11'h208;  4: return 11'h029;  5: return 11'h02A;
      6: return 11'h031;  7: return 11'h032;  8: return 11'h039;
      9: return 11'h03A;  10: return 11'h333; default: return 11'h7FF;
    endcase
  endfunction

  logic [31:0] m_ctrl [2];
  logic [31:0] m_cnt  [2];
  logic        m_ovf  [2];

  always @(posedge clk) begin
    for (int ch = 0; ch < 2; ch++) begin
      if (!rst_n) begin
        m_ctrl[ch] <= '0; m_cnt[ch] <= '0; m_ovf[ch] <= 1'b0;
      end else begin
        if (bus_we && bus_addr == 8'(4 * ch)) m_ctrl[ch] <= bus_wdata & CTRL_MASK;
        if (bus_we && bus_addr == 8'h10 && bus_wdata[1 + 8 * ch]) begin
          m_cnt[ch] <= '0; m_ovf[ch] <= 1'b0;
        end else if (barmed(m_ctrl[ch]) && bhit(m_ctrl[ch][16:6], evt_in)) begin
          m_cnt[ch] <= (m_cnt[ch] + 1) & CMAX;
          if (m_cnt[ch] == CMAX) m_ovf[ch] <= 1'b1;
        end
      end
    end
  end

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    logic [31:0] v;
    v = '0;
    case (a)
      8'h00: v = m_ctrl[0];
      8'h04: v = m_ctrl[1];
      8'h08: v = m_cnt[0];
      8'h0C: v = m_cnt[1];
      8'h10: begin v[3] = m_ovf[0]; v[11] = m_ovf[1]; end
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rd_model(input string tag, input logic [7:0] a);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp_read(a));
  endtask

  function automatic logic [31:0] ctl(input logic [10:0] code, input logic en, input logic [1:0] md);
    return {15'd0, code, 2'b00, en, 1'b0, md};
  endfunction

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a <= 16; a += 4) begin
      rd(8'(a), d);
      chk("R1 reset", d, 32'd0);
    end

    // R1 control readback keeps only defined fields
    wr(8'h00, 32'hFFFF_FFF4);
    rd(8'h00, d); chk("R1 ctrl fields", d, 32'h0001_FFC0);
    wr(8'h00, 32'd0);
    wr(8'h08, 32'h0000_0123);
    rd(8'h08, d); chk("R1 count write ignored", d, 32'd0);
    rd(8'h01, d); chk("R1 misaligned", d, 32'd0);

    // R10 enable sequence: exact start cycle
    wr(8'h00, ctl(11'h000, 1'b0, 2'b11));
    wr(8'h10, 32'h0000_0002);
    wr(8'h00, ctl(11'h000, 1'b1, 2'b11));
    repeat (4) @(negedge clk);
    rd(8'h08, d); chk("R10 start after write", d, 32'd5);

    // R6 disable holds the value
    wr(8'h00, ctl(11'h000, 1'b0, 2'b11) & ~32'h0001_FFC8);
    rd(8'h08, d);
    begin
      logic [31:0] held;
      held = d;
      repeat (10) @(negedge clk);
      rd(8'h08, d); chk("R6 hold", d, held);
    end

    // R2 each arming bit missing
    for (int b = 0; b < 3; b++) begin
      logic [31:0] c;
      c = ctl(11'h000, 1'b1, 2'b11);
      c[b == 0 ? 3 : (b == 1 ? 1 : 0)] = 1'b0;
      wr(8'h10, 32'h0000_0202);
      wr(8'h04, c);
      repeat (8) @(negedge clk);
      rd(8'h0C, d); chk("R2 not armed", d, 32'd0);
    end

    // R4 every mapped code with random strobes, R5 unmapped codes
    evt_rand_en = 9'h1FF;
    for (int k = 0; k < 12; k++) begin
      wr(8'h10, 32'h0000_0202);
      wr(8'h00, ctl(pick_code(k), 1'b1, 2'b11));
      wr(8'h04, ctl(pick_code(11 - k), 1'b1, 2'b11));
      repeat (20) @(negedge clk);
      rd_model(k < 10 ? "R4 code ch0" : "R5 unmapped ch0", 8'h08);
      rd_model((11 - k) < 10 ? "R4 code ch1" : "R5 unmapped ch1", 8'h0C);
    end
    evt_rand_en = '0;
    evt_force = 9'h1FF;
    wr(8'h10, 32'h0000_0002);
    wr(8'h00, ctl(11'h333, 1'b1, 2'b11));
    repeat (10) @(negedge clk);
    rd(8'h08, d); chk("R5 all strobes high", d, 32'd0);

    // R3 single strobe bit, exact count
    evt_force = 9'b0_0000_0001;
    wr(8'h00, ctl(11'h202, 1'b0, 2'b11));
    wr(8'h10, 32'h0000_0002);
    wr(8'h00, ctl(11'h202, 1'b1, 2'b11));
    repeat (6) @(negedge clk);
    evt_force = '0;
    repeat (3) @(negedge clk);
    rd_model("R3 count per strobe", 8'h08);
    evt_force = '0;

    // R7 clear one channel only, clear beats event
    wr(8'h04, ctl(11'h000, 1'b1, 2'b11));
    wr(8'h00, ctl(11'h000, 1'b1, 2'b11));
    repeat (5) @(negedge clk);
    wr(8'h10, 32'h0000_0002);
    rd_model("R7 cleared ch0", 8'h08);
    rd_model("R7 ch1 untouched", 8'h0C);
    rd(8'h10, d); chk("R7 clear bits read zero", d & 32'h0000_0202, 32'd0);

    // R8 overflow on ch1
    wr(8'h10, 32'h0000_0200);
    repeat (1030) @(negedge clk);
    rd(8'h10, d); chk("R8 flag ch1", d[11], 1'b1);
    rd_model("R8 wrapped count", 8'h0C);
    rd_model("R8 shared word", 8'h10);
    wr(8'h10, 32'h0000_0200);
    rd(8'h10, d); chk("R8 flag cleared", d[11], 1'b0);

    // R9 reserved bits: no effect, read zero
    wr(8'h10, 32'h0101_0101);
    rd_model("R9 count kept ch0", 8'h08);
    rd(8'h10, d); chk("R9 reserved read", d & 32'h0101_0101, 32'd0);

    // random mixed phase, all requirements against the model
    evt_rand_en = 9'h1FF;
    for (int n = 0; n < 600; n++) begin
      int op;
      op = int'($urandom % 6);
      case (op)
        0: wr(8'($urandom % 2) << 2,
              ctl(pick_code(int'($urandom % 12)), ($urandom % 4) != 0, 2'($urandom % 8 == 0 ? $urandom : 3)));
        1: wr(8'h10, $urandom & 32'h0101_0303);
        2: rd_model("R3 random count ch0", 8'h08);
        3: rd_model("R3 random count ch1", 8'h0C);
        4: rd_model("R8 random shared", 8'h10);
        default: repeat (int'($urandom % 40)) @(negedge clk);
      endcase
    end
    rd_model("R1 random ctrl ch0", 8'h00);
    rd_model("R1 random ctrl ch1", 8'h04);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule